// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

The block sits behind a UART byte receiver. Each byte arrives with a one-cycle valid strobe and two line-error flags. The block parses framed commands, each laid out as a start marker, an address, a command, a length, payload bytes and a checksum. It keeps a running 8-bit additive checksum while the frame streams in. It decides whether the frame is meant for this node, and it delivers accepted frames to a command consumer. The consumer sees a ready flag, the command byte, the payload count, and a payload byte chosen by index. It releases the frame with a one-cycle acknowledge.

Frames sent to other nodes are still followed through to their checksum byte, then dropped without any notice. One reserved address is an escape: it hands itself to the consumer as a command at once, with no length and no checksum. Every fault ends the frame and returns the parser to idle. On a fault the block raises a one-cycle error pulse and records a signed error code. It also counts faults per code in saturating counters, which are read through a selector.

Top module: `addr_frame_rx`

## Requirements
- R1: After reset, frm_ready and err_pulse are 0, err_code is 0 and every error counter reads 0.
- R2: While idle, only the byte 0x40 starts a frame. Any other byte raises error -5, and the parser stays idle, so a following valid frame is still accepted.
- R3: A frame whose address byte equals NODE_ID or 0x00 and whose checksum matches raises frm_ready on the clock edge that takes the checksum byte, and not before. frm_cmd then shows the command byte and frm_len the payload count. rd_byte shows payload byte rd_idx, with index 0 the first payload byte.
- R4: A frame with a matching checksum and any other address (not 0x7A) raises neither frm_ready nor err_pulse, and the parser is idle afterwards.
- R5: An address byte of 0x7A raises frm_ready on the edge that takes it, with frm_cmd = 0x7A and frm_len = 0. No command, length or checksum bytes are expected.
- R6: The checksum is the modulo-256 sum of the marker, address, command, length and payload bytes, and it is compared with the last byte. A mismatch raises error -1 and frm_ready stays 0.
- R7: The length byte equals the payload count plus one. A length of 0, or a length above 32, raises error -11.
- R8: A valid byte with the framing flag set raises error -3. A valid byte with only the overrun flag set raises -4. When both flags are set, -3 wins.
- R9: Any valid byte that arrives while frm_ready is 1 raises error -9 and clears frm_ready.
- R10: A frm_ack pulse clears frm_ready on the next edge, and the next frame is then accepted.
- R11: Every error gives an err_pulse lasting exactly one cycle. err_code holds the newest code until the next error. An error in mid-frame discards the partial frame and its checksum.
- R12: Each code has its own counter, which increments once per occurrence and saturates at 255. The cnt_sel values map as 0:-1, 1:-3, 2:-4, 3:-5, 4:-9, 5:-11. Values 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying rx_data and the error flags |
| rx_overrun | input | 1 | UART overrun flag for this byte |
| rx_framing_err | input | 1 | UART framing error flag for this byte |
| frm_ack | input | 1 | Consumer releases the delivered frame |
| rd_idx | input | 5 | Payload byte index for rd_byte |
| cnt_sel | input | 3 | Error counter selector |
| frm_ready | output | 1 | A frame awaits the consumer |
| frm_cmd | output | 8 | Command byte of the delivered frame |
| frm_len | output | 6 | Payload byte count of the delivered frame |
| rd_byte | output | 8 | Payload byte at rd_idx |
| err_pulse | output | 1 | One-cycle error indication |
| err_code | output | 8 | Signed code of the most recent error |
| cnt_val | output | 8 | Value of the selected error counter |

## Verification
The checker assumes that rx_valid is a single-cycle strobe and that the two error flags have meaning only while it is high. It also assumes that frm_ack is never raised in the same cycle as a byte. The bench drives each byte for exactly one cycle and lowers the flags together with the strobe. It only acknowledges when no byte is in flight, so a deliberate busy collision always comes from a byte sent while the frame is still unacknowledged.

// File: rtl/addr_frame_rx.sv
module addr_frame_rx #(
  parameter logic [7:0] NODE_ID   = 8'h05,
  parameter int         BUF_DEPTH = 32,
  parameter int         CNT_W     = 8,
  localparam int        IDX_W     = $clog2(BUF_DEPTH),
  localparam int        LEN_W     = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              rx_data,
  input  logic                    rx_valid,
  input  logic                    rx_overrun,
  input  logic                    rx_framing_err,
  input  logic                    frm_ack,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [2:0]              cnt_sel,
  output logic                    frm_ready,
  output logic [7:0]              frm_cmd,
  output logic [LEN_W-1:0]        frm_len,
  output logic [7:0]              rd_byte,
  output logic                    err_pulse,
  output logic signed [7:0]       err_code,
  output logic [CNT_W-1:0]        cnt_val
);
  localparam logic [7:0] MARK = 8'h40;
  localparam logic [7:0] ESC  = 8'h7A;
  localparam int         NCODE = 6;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_LEN, S_BODY} st_t;
  st_t st;

  logic [7:0]       sum;
  logic             hit;
  logic [LEN_W-1:0] remain, wr_idx;
  logic [7:0]       mem [BUF_DEPTH];
  logic [CNT_W-1:0] cnt [NCODE];

  logic             bad;
  logic signed [7:0] code;
  logic [2:0]       sel;

  always_comb begin
    bad = 1'b0; code = '0; sel = '0;
    if (rx_valid) begin
      if (rx_framing_err)   begin bad = 1'b1; code = -8'sd3;  sel = 3'd1; end
      else if (rx_overrun)  begin bad = 1'b1; code = -8'sd4;  sel = 3'd2; end
      else if (frm_ready)   begin bad = 1'b1; code = -8'sd9;  sel = 3'd4; end
      else begin
        unique case (st)
          S_IDLE: if (rx_data != MARK) begin bad = 1'b1; code = -8'sd5; sel = 3'd3; end
          S_LEN:  if (rx_data == 8'd0 || rx_data > BUF_DEPTH)
                    begin bad = 1'b1; code = -8'sd11; sel = 3'd5; end
          S_BODY: if (remain == LEN_W'(1) && rx_data != sum)
                    begin bad = 1'b1; code = -8'sd1; sel = 3'd0; end
          default: ;
        endcase
      end
    end
  end

  wire take   = rx_valid && !bad;
  wire wr_en  = take && st == S_BODY && remain != LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sum <= '0; hit <= 1'b0; remain <= '0; wr_idx <= '0;
      frm_ready <= 1'b0; frm_cmd <= '0; frm_len <= '0;
      err_pulse <= 1'b0; err_code <= '0;
      for (int i = 0; i < NCODE; i++) cnt[i] <= '0;
    end else begin
      err_pulse <= 1'b0;
      if (frm_ack) frm_ready <= 1'b0;
      if (rx_valid && bad) begin
        st <= S_IDLE; sum <= '0; frm_ready <= 1'b0;
        err_pulse <= 1'b1; err_code <= code;
        if (cnt[sel] != '1) cnt[sel] <= cnt[sel] + 1'b1;
      end else if (take) begin
        unique case (st)
          S_IDLE: begin st <= S_ADDR; sum <= rx_data; end
          S_ADDR: if (rx_data == ESC) begin
                    st <= S_IDLE; sum <= '0; frm_ready <= 1'b1;
                    frm_cmd <= rx_data; frm_len <= '0;
                  end else begin
                    st <= S_CMD; sum <= sum + rx_data;
                    hit <= (rx_data == NODE_ID) || (rx_data == 8'd0);
                  end
          S_CMD:  begin st <= S_LEN; sum <= sum + rx_data; frm_cmd <= rx_data; end
          S_LEN:  begin st <= S_BODY; sum <= sum + rx_data;
                    remain <= rx_data[LEN_W-1:0]; wr_idx <= '0; end
          S_BODY: if (remain == LEN_W'(1)) begin
                    st <= S_IDLE; sum <= '0;
                    if (hit) begin frm_ready <= 1'b1; frm_len <= wr_idx; end
                  end else begin
                    sum <= sum + rx_data; remain <= remain - 1'b1; wr_idx <= wr_idx + 1'b1;
                  end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) if (wr_en) mem[wr_idx[IDX_W-1:0]] <= rx_data;

  assign rd_byte = mem[rd_idx];
  assign cnt_val = (cnt_sel < 3'(NCODE)) ? cnt[cnt_sel] : '0;
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_overrun,
  input logic              rx_framing_err,
  input logic              frm_ack,
  input logic              frm_ready,
  input logic [7:0]        frm_cmd,
  input logic              err_pulse,
  input logic signed [7:0] err_code
);
  // R8
  framing_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_framing_err |=> err_pulse && err_code == -8'sd3);
  // R8
  overrun_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_framing_err && rx_overrun |=> err_pulse && err_code == -8'sd4);
  // R9
  busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && frm_ready && !rx_framing_err && !rx_overrun |=> err_code == -8'sd9 && !frm_ready);
  // R11
  pulse_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !err_pulse);
  // R11
  error_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !frm_ready);
  // R10
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready && !frm_ack && !rx_valid |=> frm_ready && $stable(frm_cmd));
  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ack && !rx_valid |=> !frm_ready);
endmodule

bind addr_frame_rx frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
  .rx_framing_err(rx_framing_err), .frm_ack(frm_ack), .frm_ready(frm_ready),
  .frm_cmd(frm_cmd), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/addr_frame_rx_tb_top.sv
module addr_frame_rx_tb_top;
  localparam logic [7:0] ID = 8'h05;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_overrun = 0, rx_framing_err = 0, frm_ack = 0;
  logic [4:0] rd_idx = 0;
  logic [2:0] cnt_sel = 0;
  logic frm_ready, err_pulse;
  logic [7:0] frm_cmd, rd_byte, cnt_val;
  logic [5:0] frm_len;
  logic signed [7:0] err_code;

  int n_chk = 0, n_err = 0;
  int exp_cnt [8];
  logic [7:0] pl [32];

  always #2 clk = ~clk;

  addr_frame_rx #(.NODE_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_overrun(rx_overrun), .rx_framing_err(rx_framing_err), .frm_ack(frm_ack),
    .rd_idx(rd_idx), .cnt_sel(cnt_sel), .frm_ready(frm_ready), .frm_cmd(frm_cmd),
    .frm_len(frm_len), .rd_byte(rd_byte), .err_pulse(err_pulse),
    .err_code(err_code), .cnt_val(cnt_val));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic ovr = 0, logic fe = 0);
    @(negedge clk); rx_data = b; rx_valid = 1; rx_overrun = ovr; rx_framing_err = fe;
    @(negedge clk); rx_valid = 0; rx_overrun = 0; rx_framing_err = 0;
  endtask

  task automatic ack();
    @(negedge clk); frm_ack = 1;
    @(negedge clk); frm_ack = 0;
  endtask

  task automatic expect_err(string req, int code, int sel);
    chk(req, int'(err_pulse), 1);
    chk(req, int'(err_code), code);
    exp_cnt[sel] = (exp_cnt[sel] < 255) ? exp_cnt[sel] + 1 : 255;
    @(negedge clk);
    chk(req, int'(err_pulse), 0);
    chk(req, int'(frm_ready), 0);
  endtask

  task automatic send_frame(logic [7:0] addr, logic [7:0] cmd, int n, logic corrupt = 0);
    logic [7:0] s;
    for (int i = 0; i < n; i++) pl[i] = 8'(cmd + 8'h13 * i + 1);
    s = 8'h40 + addr + cmd + 8'(n + 1);
    send(8'h40); send(addr); send(cmd); send(8'(n + 1));
    for (int i = 0; i < n; i++) begin send(pl[i]); s = s + pl[i]; end
    chk("R3", int'(frm_ready), 0);
    send(corrupt ? s ^ 8'h01 : s);
  endtask

  task automatic t_reset();
    chk("R1", int'(frm_ready), 0);
    chk("R1", int'(err_pulse), 0);
    chk("R1", int'(err_code), 0);
    for (int k = 0; k < 8; k++) begin cnt_sel = 3'(k); #1 chk("R1", int'(cnt_val), 0); end
  endtask

  task automatic t_good(logic [7:0] addr, logic [7:0] cmd, int n);
    send_frame(addr, cmd, n);
    chk("R3", int'(frm_ready), 1);
    chk("R3", int'(frm_cmd), int'(cmd));
    chk("R3", int'(frm_len), n);
    chk("R3", int'(err_pulse), 0);
    for (int i = 0; i < n; i++) begin rd_idx = 5'(i); #1 chk("R3", int'(rd_byte), int'(pl[i])); end
    @(negedge clk); @(negedge clk);
    chk("R10", int'(frm_ready), 1);
    ack();
    chk("R10", int'(frm_ready), 0);
  endtask

  task automatic t_other_addr();
    send_frame(8'h09, 8'h21, 3);
    chk("R4", int'(frm_ready), 0);
    chk("R4", int'(err_pulse), 0);
    t_good(ID, 8'h22, 1);
  endtask

  task automatic t_escape();
    send(8'h40); send(8'h7A);
    chk("R5", int'(frm_ready), 1);
    chk("R5", int'(frm_cmd), 8'h7A);
    chk("R5", int'(frm_len), 0);
    ack();
    chk("R10", int'(frm_ready), 0);
  endtask

  task automatic t_bad_sum();
    send_frame(ID, 8'h31, 4, 1);
    expect_err("R6", -1, 0);
  endtask

  task automatic t_bad_len();
    send(8'h40); send(ID); send(8'h01); send(8'd0);
    expect_err("R7", -11, 5);
    send(8'h40); send(ID); send(8'h01); send(8'd33);
    expect_err("R7", -11, 5);
    t_good(ID, 8'h44, 31);
  endtask

  task automatic t_uart();
    send(8'h40); send(ID, 0, 1);
    expect_err("R8", -3, 1);
    send(8'h40); send(ID, 1, 0);
    expect_err("R8", -4, 2);
    send(8'h40, 1, 1);
    expect_err("R8", -3, 1);
    send(8'h40); send(ID); send(8'h55);
    send(8'h00, 1, 0);
    expect_err("R11", -4, 2);
    chk("R11", int'(err_code), -4);
    t_good(ID, 8'h56, 2);
    chk("R11", int'(err_code), -4);
  endtask

  task automatic t_busy();
    send_frame(8'h00, 8'h61, 2);
    chk("R3", int'(frm_ready), 1);
    send(8'h40);
    expect_err("R9", -9, 4);
    t_good(8'h00, 8'h62, 0);
  endtask

  task automatic t_idle_junk();
    send(8'h3F);
    expect_err("R2", -5, 3);
    t_good(ID, 8'h71, 1);
  endtask

  task automatic t_counters();
    for (int i = 0; i < 260; i++) send(8'h00);
    for (int i = 0; i < 260; i++) exp_cnt[3] = (exp_cnt[3] < 255) ? exp_cnt[3] + 1 : 255;
    chk("R2", int'(err_code), -5);
    for (int k = 0; k < 8; k++) begin cnt_sel = 3'(k); #1 chk("R12", int'(cnt_val), exp_cnt[k]); end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) exp_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_good(ID, 8'h10, 5);
    t_good(8'h00, 8'h11, 0);
    t_other_addr();
    t_escape();
    t_bad_sum();
    t_bad_len();
    t_uart();
    t_busy();
    t_idle_junk();
    t_counters();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule